// File: doc/BRIEF.md
# Memory Write Protection Checker

This block stands between two write initiators, a CPU port and a DMA port, and a bank of RAM blocks. For each write request it decides in the same cycle whether the write may reach memory. The decision looks at the target block, which is selected by the top address bits. It also uses each block's CPU and DMA write-protect bits and each block's owning subsystem. For a dedicated block the owner is the subsystem the block belongs to. For a shared block the owner is the subsystem selected as its master. Finally, it uses a debug qualifier carried by each request.

A write that breaks a rule is suppressed. The violation is recorded per initiator: a sticky flag, the faulting address, and, for DMA, whether the cause was ownership or the protect bit. An interrupt per initiator is raised when its enable bit is set. Software clears each flag with a write-1-to-clear pulse. The first faulting address is held until that clear. Two blocks, chosen by parameter, carry no protection at all.

Top module: `wprot_gate`

## Requirements
- R1: `cpu_wr_ok` is 1 in the same cycle as a CPU request unless the target block (index = top log2(NBLK) address bits) has its `cfg_cpu_wp` bit set. In that case it is 0. It is always 0 when `cpu_req` is 0.
- R2: A DMA write is permitted only when `cfg_owner[block]` equals `dma_sub`. Otherwise `dma_wr_ok` is 0, which is an ownership violation.
- R3: A DMA write that passes the ownership test is still suppressed (`dma_wr_ok` = 0) when the block's `cfg_dma_wp` bit is set.
- R4: A request with its debug qualifier set is always granted on either port and never records a violation, whatever the protect and owner settings are.
- R5: Writes to blocks OPEN_A and OPEN_B are always granted on both ports and never record a violation.
- R6: A suppressed write sets that port's flag at the next clock edge. CPU and DMA capture are independent, and violations on both ports in the same cycle are both recorded.
- R7: The faulting address is latched when the flag is clear. While the flag is set, later violations leave the address unchanged.
- R8: A one-cycle `clr_cpu`/`clr_dma` pulse clears its flag at the next edge. If a violation arrives in the same cycle as the clear, the flag stays set and the new address is latched.
- R9: `dma_vcause` is latched together with the DMA address: 1 means an ownership violation, 0 means a protect-bit violation.
- R10: `cpu_irq` equals `cpu_flag` AND `irq_en[0]`, and `dma_irq` equals `dma_flag` AND `irq_en[1]`.
- R11: After reset the flags, addresses, cause and interrupts are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | CPU write request |
| cpu_addr | input | AW | CPU write address |
| cpu_dbg | input | 1 | CPU request is a debug access |
| dma_req | input | 1 | DMA write request |
| dma_addr | input | AW | DMA write address |
| dma_sub | input | 1 | Subsystem issuing the DMA write |
| dma_dbg | input | 1 | DMA request is a debug access |
| cfg_owner | input | NBLK | Owning or master subsystem per block |
| cfg_cpu_wp | input | NBLK | CPU write-protect bit per block |
| cfg_dma_wp | input | NBLK | DMA write-protect bit per block |
| irq_en | input | 2 | Interrupt enables: bit 0 CPU, bit 1 DMA |
| clr_cpu | input | 1 | Write-1-to-clear for the CPU flag |
| clr_dma | input | 1 | Write-1-to-clear for the DMA flag |
| cpu_wr_ok | output | 1 | CPU write may proceed |
| dma_wr_ok | output | 1 | DMA write may proceed |
| cpu_flag | output | 1 | CPU violation flag |
| dma_flag | output | 1 | DMA violation flag |
| cpu_vaddr | output | AW | First CPU faulting address |
| dma_vaddr | output | AW | First DMA faulting address |
| dma_vcause | output | 1 | DMA cause: 1 ownership, 0 protect bit |
| cpu_irq | output | 1 | CPU violation interrupt |
| dma_irq | output | 1 | DMA violation interrupt |

## Verification
The assertions check these rules on every cycle:
- debug and unprotected-block requests are granted;
- a foreign-owner DMA write is refused;
- a refused write sets its flag;
- an uncleared flag stays set with its address stable;
- a lone clear empties the flag;
- an interrupt never rises without its flag.

Some behaviour can only be shown by the bench's scenarios, which compare against exact expected values:
- the exact latched address and cause;
- that the first address survives a second violation;
- that a clear racing a new violation latches the new address;
- that simultaneous CPU and DMA faults land in separate registers;
- that the enable masks the interrupt.

// File: rtl/wprot_gate.sv
module wprot_gate #(
  parameter int NBLK   = 8,
  parameter int AW     = 12,
  parameter int OPEN_A = 0,
  parameter int OPEN_B = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic [AW-1:0]   cpu_addr,
  input  logic            cpu_dbg,
  input  logic            dma_req,
  input  logic [AW-1:0]   dma_addr,
  input  logic            dma_sub,
  input  logic            dma_dbg,
  input  logic [NBLK-1:0] cfg_owner,
  input  logic [NBLK-1:0] cfg_cpu_wp,
  input  logic [NBLK-1:0] cfg_dma_wp,
  input  logic [1:0]      irq_en,
  input  logic            clr_cpu,
  input  logic            clr_dma,
  output logic            cpu_wr_ok,
  output logic            dma_wr_ok,
  output logic            cpu_flag,
  output logic            dma_flag,
  output logic [AW-1:0]   cpu_vaddr,
  output logic [AW-1:0]   dma_vaddr,
  output logic            dma_vcause,
  output logic            cpu_irq,
  output logic            dma_irq
);
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam logic [BW-1:0] OA = BW'(OPEN_A);
  localparam logic [BW-1:0] OB = BW'(OPEN_B);

  logic [BW-1:0] cblk, dblk;
  logic c_open, d_open, c_chk, d_chk;
  logic c_viol, d_nm, d_pv, d_viol;
  logic c_cap, d_cap;

  assign cblk   = cpu_addr[AW-1 -: BW];
  assign dblk   = dma_addr[AW-1 -: BW];
  assign c_open = (cblk == OA) || (cblk == OB);
  assign d_open = (dblk == OA) || (dblk == OB);

  assign c_chk  = cpu_req && !cpu_dbg && !c_open;
  assign d_chk  = dma_req && !dma_dbg && !d_open;

  assign c_viol = c_chk && cfg_cpu_wp[cblk];
  assign d_nm   = d_chk && (cfg_owner[dblk] != dma_sub);
  assign d_pv   = d_chk && (cfg_owner[dblk] == dma_sub) && cfg_dma_wp[dblk];
  assign d_viol = d_nm || d_pv;

  assign cpu_wr_ok = cpu_req && !c_viol;
  assign dma_wr_ok = dma_req && !d_viol;

  assign c_cap = c_viol && (!cpu_flag || clr_cpu);
  assign d_cap = d_viol && (!dma_flag || clr_dma);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_flag  <= 1'b0;
      cpu_vaddr <= '0;
    end else begin
      cpu_flag <= (cpu_flag && !clr_cpu) || c_viol;
      if (c_cap) cpu_vaddr <= cpu_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_flag   <= 1'b0;
      dma_vaddr  <= '0;
      dma_vcause <= 1'b0;
    end else begin
      dma_flag <= (dma_flag && !clr_dma) || d_viol;
      if (d_cap) begin
        dma_vaddr  <= dma_addr;
        dma_vcause <= d_nm;
      end
    end
  end

  assign cpu_irq = cpu_flag && irq_en[0];
  assign dma_irq = dma_flag && irq_en[1];
endmodule

// File: rtl/wprot_gate_chk.sv
module wprot_gate_chk #(
  parameter int NBLK   = 8,
  parameter int AW     = 12,
  parameter int OPEN_A = 0,
  parameter int OPEN_B = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_req,
  input logic [AW-1:0]   cpu_addr,
  input logic            cpu_dbg,
  input logic            dma_req,
  input logic [AW-1:0]   dma_addr,
  input logic            dma_sub,
  input logic            dma_dbg,
  input logic [NBLK-1:0] cfg_owner,
  input logic            clr_cpu,
  input logic            clr_dma,
  input logic            cpu_wr_ok,
  input logic            dma_wr_ok,
  input logic            cpu_flag,
  input logic            dma_flag,
  input logic [AW-1:0]   cpu_vaddr,
  input logic [AW-1:0]   dma_vaddr,
  input logic            cpu_irq,
  input logic            dma_irq
);
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1;
  logic [BW-1:0] cb, db;
  logic c_free, d_free;
  assign cb = cpu_addr[AW-1 -: BW];
  assign db = dma_addr[AW-1 -: BW];
  assign c_free = (cb == BW'(OPEN_A)) || (cb == BW'(OPEN_B));
  assign d_free = (db == BW'(OPEN_A)) || (db == BW'(OPEN_B));

  // R4
  dbg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_dbg) || (dma_req && dma_dbg) |-> (cpu_wr_ok || !cpu_req || !cpu_dbg) && (dma_wr_ok || !dma_req || !dma_dbg));
  // R5
  open_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && c_free) || (dma_req && d_free) |-> (!cpu_req || !c_free || cpu_wr_ok) && (!dma_req || !d_free || dma_wr_ok));
  // R2
  dma_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_dbg && !d_free && (cfg_owner[db] != dma_sub) |-> !dma_wr_ok);
  // R6
  cpu_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_wr_ok |=> cpu_flag);
  // R6
  dma_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_wr_ok |=> dma_flag);
  // R7
  cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_flag && !clr_cpu |=> cpu_flag && $stable(cpu_vaddr));
  // R7
  dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_flag && !clr_dma |=> dma_flag && $stable(dma_vaddr));
  // R8
  cpu_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cpu && !(cpu_req && !cpu_wr_ok) |=> !cpu_flag);
  // R10
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq || dma_irq) |-> (!cpu_irq || cpu_flag) && (!dma_irq || dma_flag));
endmodule

bind wprot_gate wprot_gate_chk #(.NBLK(NBLK), .AW(AW), .OPEN_A(OPEN_A), .OPEN_B(OPEN_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_dbg(cpu_dbg),
  .dma_req(dma_req), .dma_addr(dma_addr), .dma_sub(dma_sub), .dma_dbg(dma_dbg),
  .cfg_owner(cfg_owner), .clr_cpu(clr_cpu), .clr_dma(clr_dma),
  .cpu_wr_ok(cpu_wr_ok), .dma_wr_ok(dma_wr_ok), .cpu_flag(cpu_flag), .dma_flag(dma_flag),
  .cpu_vaddr(cpu_vaddr), .dma_vaddr(dma_vaddr), .cpu_irq(cpu_irq), .dma_irq(dma_irq)
);

// File: tb/wprot_gate_bench.sv
`timescale 1ns/1ps
module wprot_gate_bench;
  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_dbg = 0, dma_req = 0, dma_sub = 0, dma_dbg = 0;
  logic [11:0] cpu_addr = 0, dma_addr = 0;
  logic [7:0] cfg_owner = 0, cfg_cpu_wp = 0, cfg_dma_wp = 0;
  logic [1:0] irq_en = 0;
  logic clr_cpu = 0, clr_dma = 0;
  logic cpu_wr_ok, dma_wr_ok, cpu_flag, dma_flag, dma_vcause, cpu_irq, dma_irq;
  logic [11:0] cpu_vaddr, dma_vaddr;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wprot_gate u_wprot_gate (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_dbg(cpu_dbg),
    .dma_req(dma_req), .dma_addr(dma_addr), .dma_sub(dma_sub), .dma_dbg(dma_dbg),
    .cfg_owner(cfg_owner), .cfg_cpu_wp(cfg_cpu_wp), .cfg_dma_wp(cfg_dma_wp), .irq_en(irq_en),
    .clr_cpu(clr_cpu), .clr_dma(clr_dma), .cpu_wr_ok(cpu_wr_ok), .dma_wr_ok(dma_wr_ok),
    .cpu_flag(cpu_flag), .dma_flag(dma_flag), .cpu_vaddr(cpu_vaddr), .dma_vaddr(dma_vaddr),
    .dma_vcause(dma_vcause), .cpu_irq(cpu_irq), .dma_irq(dma_irq));

  function automatic logic [11:0] ad(input int b, input int off);
    return {3'(b), 9'(off)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [11:0] a, input logic dbg, output logic ok);
    cpu_req = 1; cpu_addr = a; cpu_dbg = dbg;
    #1 ok = cpu_wr_ok;
    @(negedge clk); cpu_req = 0; cpu_dbg = 0;
  endtask

  task automatic dma_wr(input logic [11:0] a, input logic sub, input logic dbg, output logic ok);
    dma_req = 1; dma_addr = a; dma_sub = sub; dma_dbg = dbg;
    #1 ok = dma_wr_ok;
    @(negedge clk); dma_req = 0; dma_dbg = 0;
  endtask

  task automatic clear_both();
    clr_cpu = 1; clr_dma = 1;
    @(negedge clk); clr_cpu = 0; clr_dma = 0;
  endtask

  task automatic t_reset();
    check("R11 cpu_flag", cpu_flag, 0);
    check("R11 dma_flag", dma_flag, 0);
    check("R11 cpu_vaddr", cpu_vaddr, 0);
    check("R11 dma_vaddr", dma_vaddr, 0);
    check("R11 cause", dma_vcause, 0);
    check("R11 irqs", {cpu_irq, dma_irq}, 0);
  endtask

  task automatic t_cpu_protect();
    logic ok;
    cfg_cpu_wp = 8'b0001_0100;
    #1 check("R1 idle no grant", cpu_wr_ok, 0);
    cpu_wr(ad(3, 9'h012), 0, ok);
    check("R1 unprotected grant", ok, 1);
    check("R6 no flag on grant", cpu_flag, 0);
    cpu_wr(ad(2, 9'h055), 0, ok);
    check("R1 protected blocked", ok, 0);
    check("R6 cpu flag", cpu_flag, 1);
    check("R7 cpu addr", cpu_vaddr, ad(2, 9'h055));
    cpu_wr(ad(4, 9'h1aa), 0, ok);
    check("R1 second blocked", ok, 0);
    check("R7 first addr held", cpu_vaddr, ad(2, 9'h055));
    clr_cpu = 1; @(negedge clk); clr_cpu = 0;
    check("R8 cpu cleared", cpu_flag, 0);
    cfg_cpu_wp = 0;
  endtask

  task automatic t_dma_owner();
    logic ok;
    cfg_owner = 8'b0010_0000;
    dma_wr(ad(5, 9'h010), 1, 0, ok);
    check("R2 owner grant", ok, 1);
    check("R2 no flag", dma_flag, 0);
    dma_wr(ad(5, 9'h0f0), 0, 0, ok);
    check("R2 non-owner blocked", ok, 0);
    check("R6 dma flag", dma_flag, 1);
    check("R9 cause ownership", dma_vcause, 1);
    check("R7 dma addr", dma_vaddr, ad(5, 9'h0f0));
    cfg_dma_wp = 8'b0100_0000;
    dma_wr(ad(6, 9'h001), 0, 0, ok);
    check("R3 held flag blocked", ok, 0);
    check("R9 cause held", dma_vcause, 1);
    check("R7 dma addr held", dma_vaddr, ad(5, 9'h0f0));
    clr_dma = 1; @(negedge clk); clr_dma = 0;
    check("R8 dma cleared", dma_flag, 0);
  endtask

  task automatic t_dma_protect();
    logic ok;
    dma_wr(ad(7, 9'h033), 0, 0, ok);
    check("R3 unprotected owned grant", ok, 1);
    dma_wr(ad(6, 9'h044), 0, 0, ok);
    check("R3 protected blocked", ok, 0);
    check("R9 cause protect", dma_vcause, 0);
    check("R3 addr", dma_vaddr, ad(6, 9'h044));
    clear_both();
    cfg_dma_wp = 0;
  endtask

  task automatic t_debug();
    logic ok;
    cfg_cpu_wp = 8'hff; cfg_dma_wp = 8'hff; cfg_owner = 8'h00;
    cpu_wr(ad(3, 9'h100), 1, ok);
    check("R4 cpu debug grant", ok, 1);
    dma_wr(ad(4, 9'h100), 1, 1, ok);
    check("R4 dma debug grant", ok, 1);
    check("R4 no flags", {cpu_flag, dma_flag}, 0);
  endtask

  task automatic t_open();
    logic ok;
    cpu_wr(ad(0, 9'h001), 0, ok);
    check("R5 cpu block0", ok, 1);
    cpu_wr(ad(1, 9'h1ff), 0, ok);
    check("R5 cpu block1", ok, 1);
    dma_wr(ad(0, 9'h002), 1, 0, ok);
    check("R5 dma block0", ok, 1);
    dma_wr(ad(1, 9'h003), 1, 0, ok);
    check("R5 dma block1", ok, 1);
    check("R5 no flags", {cpu_flag, dma_flag}, 0);
  endtask

  task automatic t_both();
    cpu_req = 1; cpu_addr = ad(2, 9'h0c0); dma_req = 1; dma_addr = ad(6, 9'h0d0); dma_sub = 1;
    #1 check("R6 both blocked", {cpu_wr_ok, dma_wr_ok}, 0);
    @(negedge clk); cpu_req = 0; dma_req = 0;
    check("R6 both flags", {cpu_flag, dma_flag}, 2'b11);
    check("R6 cpu own addr", cpu_vaddr, ad(2, 9'h0c0));
    check("R6 dma own addr", dma_vaddr, ad(6, 9'h0d0));
  endtask

  task automatic t_irq();
    irq_en = 2'b00; #1;
    check("R10 masked", {cpu_irq, dma_irq}, 0);
    irq_en = 2'b01; #1;
    check("R10 cpu only", {cpu_irq, dma_irq}, 2'b10);
    irq_en = 2'b10; #1;
    check("R10 dma only", {cpu_irq, dma_irq}, 2'b01);
    irq_en = 2'b11;
    @(negedge clk);
  endtask

  task automatic t_clear_race();
    clr_cpu = 1; cpu_req = 1; cpu_addr = ad(5, 9'h0ee);
    @(negedge clk); clr_cpu = 0; cpu_req = 0;
    check("R8 race flag kept", cpu_flag, 1);
    check("R8 race new addr", cpu_vaddr, ad(5, 9'h0ee));
    check("R10 irq on", cpu_irq, 1);
    clear_both();
    check("R8 both cleared", {cpu_flag, dma_flag}, 0);
    check("R10 irq off", {cpu_irq, dma_irq}, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cpu_protect();
    t_dma_owner();
    t_dma_protect();
    t_debug();
    t_open();
    t_both();
    t_irq();
    t_clear_race();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule